// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a simple 32-bit fetch path and works out where the next instruction lies. Each time the `advance` strobe is high at a rising clock edge, it reads the current instruction word and a flag that says whether the instruction's two register operands are equal. From these it picks one of four flow kinds and loads the resulting address into the counter. It also records whether that update left straight-line flow.

Decoding puts every instruction into one of four named flow states. FLOW_SEQ covers any ordinary instruction and moves to PC + 4. FLOW_BEQ and FLOW_BNE are the two conditional branches. A taken branch moves to PC + 4 plus four times the sign-extended 16-bit offset, and a branch that is not taken falls through to PC + 4. FLOW_JUMP replaces the low 28 bits of the counter and keeps the top four bits, so the counter stays in its current 256 MB region. The flow state is chosen fresh on every update. The only transitions are from the decoded opcode into one of these four states, and each state leads back to the counter register. A synchronous reset sends the counter to the reset address.

Top module: `npc_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes 0 and `taken` becomes 0 on that edge. Reset wins over `advance`.
- R2: When `advance` is low and `rst` is low at an edge, `pc` and `taken` keep their values, whatever `instr` and `ops_equal` hold.
- R3: An opcode in `instr[31:26]` other than 000100, 000101 or 000010 selects FLOW_SEQ. `pc` becomes `pc + 4` and `taken` becomes 0. This includes codes that differ from a branch code by a single bit.
- R4: When opcode 000100 (FLOW_BEQ) arrives with `ops_equal` = 1, `pc` becomes `pc + 4 + 4*sext(instr[15:0])` and `taken` becomes 1.
- R5: When opcode 000100 arrives with `ops_equal` = 0, `pc` becomes `pc + 4` and `taken` becomes 0.
- R6: Opcode 000101 (FLOW_BNE) goes to the branch target with `taken` = 1 when `ops_equal` = 0. With `ops_equal` = 1 it moves to `pc + 4` with `taken` = 0.
- R7: The branch offset is signed, so a negative offset moves `pc` backwards. Offset 0xFFFF leaves `pc` unchanged, and offset 0x8000 moves it back by 0x1FFFC.
- R8: Opcode 000010 (FLOW_JUMP) gives `pc = {pc[31:28], instr[25:0], 2'b00}` and sets `taken` = 1 whatever `ops_equal` is. The top four bits are never altered.
- R9: `pc` stays word aligned, with bits [1:0] always 0. The sequential step from 0x0FFFFFFC carries into bit 28 and reaches 0x10000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Take one update on this edge |
| instr | input | 32 | Instruction word at the current `pc` |
| ops_equal | input | 1 | High when the two register operands are equal |
| pc | output | 32 | Registered program counter |
| taken | output | 1 | Last update was a taken branch or a jump |

## Verification
The bench goes after the signed branch offset in three ways: an offset of -1 must hold the counter in place, and the most negative offset must step back by almost 128 KB. A design that zero-extends the offset would instead jump far forward. It also checks a branch that is taken against the already-incremented PC, where a design using the old PC would land four bytes short. A run walks the counter across a 256 MB boundary with a sequential step and then issues a jump. A design that takes the region bits from the wrong place, or clears them, would fall back to region 0. Further checks cover an opcode one bit away from a branch code, which must not branch, and a jump with `ops_equal` set, which must not be treated as a branch. The reset-over-advance and hold cases catch a counter that updates when it should not.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_JUMP = 6'b000010;

    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_BEQ  = 2'd1,
        FLOW_BNE  = 2'd2,
        FLOW_JUMP = 2'd3
    } flow_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output flow_e            flow
);

    // Opcode to flow state; anything unrecognised runs straight on.
    always_comb begin
        unique case (opcode)
            OPC_BEQ:  flow = FLOW_BEQ;
            OPC_BNE:  flow = FLOW_BNE;
            OPC_JUMP: flow = FLOW_JUMP;
            default:  flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [IMM_W-1:0]  offset,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   br_pc,
    output logic [XLEN-1:0]   jmp_pc
);

    localparam int ALIGN_W  = 2;
    localparam int REGION_W = XLEN - JIDX_W - ALIGN_W;
    localparam int EXT_W    = XLEN - IMM_W - ALIGN_W;

    logic [XLEN-1:0] br_disp;

    assign seq_pc  = pc + XLEN'(4);
    // Sign extension and word scaling in one concatenation.
    assign br_disp = {{EXT_W{offset[IMM_W-1]}}, offset, {ALIGN_W{1'b0}}};
    assign br_pc   = seq_pc + br_disp;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_pc = {pc[XLEN-1 -: REGION_W], jidx, {ALIGN_W{1'b0}}};
        end else begin : g_flat
            assign jmp_pc = XLEN'({jidx, {ALIGN_W{1'b0}}});
        end
    endgenerate

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               IMM_W    = 16,
    parameter int               JIDX_W   = 26,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic [XLEN-1:0] instr,
    input  logic            ops_equal,
    output logic [XLEN-1:0] pc,
    output logic            taken
);

    flow_e           flow;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;
    logic [XLEN-1:0] pc_nxt;
    logic            taken_nxt;

    npc_decode u_decode (
        .opcode (instr[XLEN-1 -: OPC_W]),
        .flow   (flow)
    );

    npc_target #(
        .XLEN   (XLEN),
        .IMM_W  (IMM_W),
        .JIDX_W (JIDX_W)
    ) u_target (
        .pc     (pc),
        .offset (instr[IMM_W-1:0]),
        .jidx   (instr[JIDX_W-1:0]),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .jmp_pc (jmp_pc)
    );

    // Per-state next address and taken flag.
    always_comb begin
        unique case (flow)
            FLOW_SEQ: begin
                pc_nxt    = seq_pc;
                taken_nxt = 1'b0;
            end
            FLOW_BEQ: begin
                pc_nxt    = ops_equal ? br_pc : seq_pc;
                taken_nxt = ops_equal;
            end
            FLOW_BNE: begin
                pc_nxt    = ops_equal ? seq_pc : br_pc;
                taken_nxt = ~ops_equal;
            end
            FLOW_JUMP: begin
                pc_nxt    = jmp_pc;
                taken_nxt = 1'b1;
            end
            default: begin
                pc_nxt    = seq_pc;
                taken_nxt = 1'b0;
            end
        endcase
    end

    // Counter and flag registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= RESET_PC;
            taken <= 1'b0;
        end else if (advance) begin
            pc    <= pc_nxt;
            taken <= taken_nxt;
        end
    end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            advance,
    input logic [XLEN-1:0] instr,
    input logic            ops_equal,
    input logic [XLEN-1:0] pc,
    input logic            taken
);

    logic [OPC_W-1:0] op;
    logic             is_ctl;
    assign op     = instr[XLEN-1 -: OPC_W];
    assign is_ctl = (op == OPC_BEQ) || (op == OPC_BNE) || (op == OPC_JUMP);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (pc == '0) && !taken);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(pc) && $stable(taken));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && !is_ctl) |=> (pc == $past(pc) + XLEN'(4)) && !taken);

    p_beq_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && op == OPC_BEQ && ops_equal) |=> taken);

    p_bne_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (advance && op == OPC_BNE && ops_equal) |=> !taken && (pc == $past(pc) + XLEN'(4)));

    p_jump_region_r8: assert property (@(posedge clk) disable iff (rst)
        (advance && op == OPC_JUMP) |=> taken && (pc[XLEN-1 -: 4] == $past(pc[XLEN-1 -: 4])));

    p_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .instr     (instr),
    .ops_equal (ops_equal),
    .pc        (pc),
    .taken     (taken)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        advance = 1'b0;
    logic [31:0] instr = '0;
    logic        ops_equal = 1'b0;
    logic [31:0] pc;
    logic        taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit uut (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .instr     (instr),
        .ops_equal (ops_equal),
        .pc        (pc),
        .taken     (taken)
    );

    // {instr, ops_equal, expected taken, expected pc}, walked from pc 0.
    localparam logic [65:0] VEC [NVEC] = '{
        {32'h012A4020, 1'b0, 1'b0, 32'h0000_0004},  // R3 plain op
        {32'h1109_0003, 1'b1, 1'b1, 32'h0000_0014}, // R4 beq taken
        {32'h1109_0003, 1'b0, 1'b0, 32'h0000_0018}, // R5 beq falls
        {32'h1509_0002, 1'b0, 1'b1, 32'h0000_0024}, // R6 bne taken
        {32'h1509_0002, 1'b1, 1'b0, 32'h0000_0028}, // R6 bne falls
        {32'h1109_FFFF, 1'b1, 1'b1, 32'h0000_0028}, // R7 offset -1
        {32'h1109_FFFD, 1'b1, 1'b1, 32'h0000_0020}, // R7 offset -3
        {32'h0800_0019, 1'b0, 1'b1, 32'h0000_0064}, // R8 jump
        {32'h8E48_0000, 1'b0, 1'b0, 32'h0000_0068}, // R3 load op
        {32'h0BFF_FFFF, 1'b1, 1'b1, 32'h0FFF_FFFC}, // R8 jump, eq set
        {32'h0000_0000, 1'b0, 1'b0, 32'h1000_0000}, // R9 carry into region
        {32'h0800_0010, 1'b0, 1'b1, 32'h1000_0040}, // R8 region kept
        {32'h1109_8000, 1'b1, 1'b1, 32'h0FFE_0044}, // R7 most negative
        {32'h1800_0005, 1'b1, 1'b0, 32'h0FFE_0048}  // R3 near-beq opcode
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic [31:0] i, input logic e);
        advance   = a;
        instr     = i;
        ops_equal = e;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset pc", pc, 32'h0);
        check("R1 reset taken", 32'(taken), 32'h0);
        rst = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            step(1'b1, VEC[k][65:34], VEC[k][33]);
            check($sformatf("R3-R9 vector %0d pc", k), pc, VEC[k][31:0]);
            check($sformatf("R4/R5/R6 vector %0d taken", k), 32'(taken), 32'(VEC[k][32]));
        end

        // R2: a jump without advance changes nothing.
        step(1'b0, 32'h0800_0001, 1'b1);
        check("R2 hold pc", pc, 32'h0FFE_0048);
        check("R2 hold taken", 32'(taken), 32'h0);
        step(1'b1, 32'h1109_0001, 1'b1);
        check("R4 branch before hold", pc, 32'h0FFE_0050);
        step(1'b0, 32'h0000_0000, 1'b0);
        check("R2 hold taken high", 32'(taken), 32'h1);
        check("R2 hold pc again", pc, 32'h0FFE_0050);

        // R1: reset beats advance.
        rst = 1'b1;
        step(1'b1, 32'h0800_0100, 1'b0);
        check("R1 reset over advance pc", pc, 32'h0);
        check("R1 reset over advance taken", 32'(taken), 32'h0);
        rst = 1'b0;
        step(1'b1, 32'h0000_0000, 1'b0);
        check("R3 after reset", pc, 32'h4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule